// File: doc/BRIEF.md
# Shift and Halfword Byte-Swap Unit with Status Flags

This unit takes one 32-bit operand, a 5-bit count and a 2-bit operation code. It produces a 32-bit result and four status flags: zero, sign, carry and overflow. There are four operations: a left shift that fills with zeros, a right shift that fills with zeros, a right shift that fills with copies of the sign bit, and an exchange of the two bytes inside each 16-bit half of the operand. A zero shift count always clears carry. For the byte exchange, the zero and carry flags look only at the low 16 bits of the result and at its two low bytes, never at the full word.

Each operation is framed by a valid/ready handshake. The upstream side offers an operation with `in_valid`, and the unit accepts it on any rising clock edge where `in_ready` is also high. The result and flags then sit in one output register. `out_valid` rises on the edge that accepts the operation, so the result can be read in the following cycle. The output stays there until the downstream side takes it with `out_ready`. A new operation can be accepted on the same edge that hands the old one over, so the unit can complete one operation per cycle.

Top module: `shift_swap_unit`

## Requirements
- R1: With `in_op` = 2'b00 the result is the operand shifted left by `in_count`, with vacated low bits filled with zero.
- R2: With `in_op` = 2'b01 the result is the operand shifted right by `in_count`, with vacated high bits filled with zero.
- R3: With `in_op` = 2'b10 the result is the operand shifted right by `in_count`, with vacated high bits filled with operand bit 31.
- R4: With `in_op` = 2'b11 the result swaps operand bytes [7:0] and [15:8], and swaps bytes [23:16] and [31:24]. The count is ignored.
- R5: For any of the three shifts with a count of zero, the result equals the operand and carry is 0.
- R6: For a shift with a nonzero count n, carry equals the last bit shifted out: operand bit 32-n for the left shift, and operand bit n-1 for both right shifts.
- R7: For the shifts, zero is set exactly when all 32 result bits are 0, sign equals result bit 31, and overflow is 0.
- R8: For the byte swap, zero is set exactly when result bits [15:0] are all 0, whatever bits [31:16] hold.
- R9: For the byte swap, carry is set when result bits [7:0] are all 0 or result bits [15:8] are all 0.
- R10: For the byte swap, sign equals result bit 31 and overflow is 0.
- R11: `in_ready` is high when `out_valid` is low or `out_ready` is high. An operation accepted on a clock edge is presented with `out_valid` high right after that edge.
- R12: While `out_valid` is high and `out_ready` is low, the result and flags stay unchanged and `out_valid` stays high.
- R13: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is being offered |
| in_ready | output | 1 | The unit can accept an operation this cycle |
| in_op | input | 2 | Operation code: 00 shift left, 01 logical shift right, 10 arithmetic shift right, 11 halfword byte swap |
| in_data | input | 32 | Operand |
| in_count | input | 5 | Shift count (ignored for the byte swap) |
| out_valid | output | 1 | The result register holds an operation that has not yet been taken |
| out_ready | input | 1 | Downstream takes the held result |
| out_result | output | 32 | Result of the operation |
| out_zero | output | 1 | Zero flag |
| out_sign | output | 1 | Sign flag |
| out_carry | output | 1 | Carry flag |
| out_ovf | output | 1 | Overflow flag |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is held low for at least one clock edge at start-up.
- The operation code, operand and count are settled at every edge where `in_valid` is high, because the checker records them on acceptance and ties the flags back to them.
- The upstream side may withdraw `in_valid` or change the operand between offers; nothing assumes an offer is kept up until it is accepted.

The stimulus keeps to these assumptions. It drives all inputs on the falling edge, holds reset for three edges, and mixes directed cases with random ones. The directed cases cover counts 0, 1 and 31 for every shift and words whose swapped low bytes or low half are zero. The random phase draws random operation codes, operands, counts, `in_valid` and `out_ready`, so it exercises both stalls and back-to-back transfers.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
   typedef enum logic [1:0] {
      SBU_SHL   = 2'b00,
      SBU_SHR   = 2'b01,
      SBU_SAR   = 2'b10,
      SBU_HSWAP = 2'b11
   } sbu_op_e;

   typedef struct packed {
      logic zero;
      logic sign;
      logic carry;
      logic ovf;
   } sbu_flags_t;
endpackage

// File: rtl/sbu_barrel.sv
// Log-stage right shifter with a guard bit below the LSB that collects the
// last bit shifted out. A left shift reuses the same stages on a bit-reversed word.
module sbu_barrel #(
   parameter int W  = 32,
   parameter int CW = $clog2(W)
) (
   input  logic [W-1:0]  data,
   input  logic [CW-1:0] count,
   input  logic          left,
   input  logic          arith,
   output logic [W-1:0]  result,
   output logic          carry_out
);
   localparam int EW = W + 1;

   logic [W-1:0]  src;
   logic [W-1:0]  shifted;
   logic          fill;
   logic [EW-1:0] stage [0:CW];

   always_comb begin
      for (int i = 0; i < W; i++) begin
         src[i] = left ? data[W-1-i] : data[i];
      end
   end

   assign fill     = arith & ~left & data[W-1];
   assign stage[0] = {src, 1'b0};

   for (genvar s = 0; s < CW; s++) begin : g_stage
      localparam int SH = 1 << s;
      assign stage[s+1] = count[s] ? {{SH{fill}}, stage[s][EW-1:SH]} : stage[s];
   end

   assign shifted   = stage[CW][EW-1:1];
   assign carry_out = stage[CW][0];

   always_comb begin
      for (int i = 0; i < W; i++) begin
         result[i] = left ? shifted[W-1-i] : shifted[i];
      end
   end
endmodule

// File: rtl/sbu_halfswap.sv
// Exchanges the two bytes of every 16-bit half of the word.
module sbu_halfswap #(
   parameter int W = 32
) (
   input  logic [W-1:0] data,
   output logic [W-1:0] result
);
   localparam int NHALF = W / 16;

   for (genvar h = 0; h < NHALF; h++) begin : g_half
      assign result[16*h +: 8]     = data[16*h + 8 +: 8];
      assign result[16*h + 8 +: 8] = data[16*h +: 8];
   end
endmodule

// File: rtl/sbu_flag_gen.sv
module sbu_flag_gen
   import sbu_pkg::*;
#(
   parameter int W = 32
) (
   input  sbu_op_e       op,
   input  logic [W-1:0]  result,
   input  logic          shift_carry,
   output sbu_flags_t    flags
);
   logic low_byte_z;
   logic next_byte_z;

   assign low_byte_z  = (result[7:0]  == 8'h00);
   assign next_byte_z = (result[15:8] == 8'h00);

   always_comb begin
      flags.sign = result[W-1];
      flags.ovf  = 1'b0;
      if (op == SBU_HSWAP) begin
         flags.zero  = low_byte_z & next_byte_z;
         flags.carry = low_byte_z | next_byte_z;
      end else begin
         flags.zero  = (result == '0);
         flags.carry = shift_carry;
      end
   end
endmodule

// File: rtl/sbu_out_stage.sv
// Single result register with a valid bit; optionally resets its data flops.
module sbu_out_stage #(
   parameter int DW        = 36,
   parameter bit RESET_DAT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          take,
   input  logic [DW-1:0] d,
   output logic          valid,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      valid <= 1'b0;
      else if (load)   valid <= 1'b1;
      else if (take)   valid <= 1'b0;
   end

   if (RESET_DAT) begin : g_rst_data
      always_ff @(posedge clk) begin
         if (!rst_n)    q <= '0;
         else if (load) q <= d;
      end
   end else begin : g_plain_data
      always_ff @(posedge clk) begin
         if (load) q <= d;
      end
   end
endmodule

// File: rtl/shift_swap_unit.sv
module shift_swap_unit
   import sbu_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int CNT_W         = $clog2(DATA_W),
   parameter bit RESET_DATAPTH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_op,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CNT_W-1:0]  in_count,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_result,
   output logic              out_zero,
   output logic              out_sign,
   output logic              out_carry,
   output logic              out_ovf
);
   localparam int NFLAG = $bits(sbu_flags_t);
   localparam int PW    = DATA_W + NFLAG;

   if (DATA_W < 16 || (DATA_W % 16) != 0) begin : g_bad_width
      $error("shift_swap_unit: DATA_W must be a nonzero multiple of 16");
   end
   if (CNT_W != $clog2(DATA_W)) begin : g_bad_cnt
      $error("shift_swap_unit: CNT_W must equal clog2(DATA_W)");
   end

   sbu_op_e          op;
   logic [DATA_W-1:0] sh_res;
   logic [DATA_W-1:0] sw_res;
   logic [DATA_W-1:0] sel_res;
   logic              sh_carry;
   sbu_flags_t        flags_d;
   logic              accept;
   logic [PW-1:0]     pack_d;
   logic [PW-1:0]     pack_q;
   sbu_flags_t        flags_q;

   assign op = sbu_op_e'(in_op);

   sbu_barrel #(.W(DATA_W), .CW(CNT_W)) u_barrel (
      .data      (in_data),
      .count     (in_count),
      .left      (op == SBU_SHL),
      .arith     (op == SBU_SAR),
      .result    (sh_res),
      .carry_out (sh_carry)
   );

   sbu_halfswap #(.W(DATA_W)) u_swap (
      .data   (in_data),
      .result (sw_res)
   );

   assign sel_res = (op == SBU_HSWAP) ? sw_res : sh_res;

   sbu_flag_gen #(.W(DATA_W)) u_flags (
      .op          (op),
      .result      (sel_res),
      .shift_carry (sh_carry),
      .flags       (flags_d)
   );

   assign in_ready = ~out_valid | out_ready;
   assign accept   = in_valid & in_ready;
   assign pack_d   = {sel_res, flags_d};

   sbu_out_stage #(.DW(PW), .RESET_DAT(RESET_DATAPTH)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .take  (out_ready),
      .d     (pack_d),
      .valid (out_valid),
      .q     (pack_q)
   );

   assign flags_q    = sbu_flags_t'(pack_q[NFLAG-1:0]);
   assign out_result = pack_q[PW-1:NFLAG];
   assign out_zero   = flags_q.zero;
   assign out_sign   = flags_q.sign;
   assign out_carry  = flags_q.carry;
   assign out_ovf    = flags_q.ovf;
endmodule

// File: rtl/sbu_chk.sv
module sbu_chk #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [1:0]        in_op,
   input logic [DATA_W-1:0] in_data,
   input logic [CNT_W-1:0]  in_count,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_result,
   input logic              out_zero,
   input logic              out_sign,
   input logic              out_carry,
   input logic              out_ovf
);
   logic [1:0]        cap_op;
   logic [DATA_W-1:0] cap_data;
   logic [CNT_W-1:0]  cap_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_op   <= 2'b00;
         cap_data <= '0;
         cap_cnt  <= '0;
      end else if (in_valid && in_ready) begin
         cap_op   <= in_op;
         cap_data <= in_data;
         cap_cnt  <= in_count;
      end
   end

   // R13
   reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

   // R11
   accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R12
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_carry)
                                     && $stable(out_zero) && $stable(out_sign)));

   // R5
   zero_cnt_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cap_op != 2'b11 && cap_cnt == '0) |-> (!out_carry && out_result == cap_data));

   // R3
   sar_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cap_op == 2'b10) |-> (out_sign == cap_data[DATA_W-1]));

   // R8
   swap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cap_op == 2'b11) |-> (out_zero == (cap_data[15:0] == 16'h0000)));

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !out_ovf);
endmodule

bind shift_swap_unit sbu_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_op      (in_op),
   .in_data    (in_data),
   .in_count   (in_count),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_result (out_result),
   .out_zero   (out_zero),
   .out_sign   (out_sign),
   .out_carry  (out_carry),
   .out_ovf    (out_ovf)
);

// File: tb/shift_swap_unit_tb.sv
`timescale 1ns/100ps
module shift_swap_unit_tb;
   typedef struct {
      logic [1:0]  op;
      logic [31:0] res;
      logic        z, s, c, v;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_op = 2'b00;
   logic [31:0] in_data = '0;
   logic [4:0]  in_count = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_result;
   logic        out_zero, out_sign, out_carry, out_ovf;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 0;
   exp_t q[$];
   bit          was_stalled = 0;
   logic [31:0] stalled_res;

   always #2.5 clk = ~clk;

   shift_swap_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_data(in_data), .in_count(in_count),
      .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
      .out_zero(out_zero), .out_sign(out_sign), .out_carry(out_carry), .out_ovf(out_ovf)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [1:0] op, input logic [31:0] d, input int c);
      exp_t e;
      e.op = op;
      e.v  = 1'b0;
      case (op)
         2'b00: begin e.res = d << c; e.c = (c == 0) ? 1'b0 : d[32-c]; end
         2'b01: begin e.res = d >> c; e.c = (c == 0) ? 1'b0 : d[c-1]; end
         2'b10: begin e.res = $signed(d) >>> c; e.c = (c == 0) ? 1'b0 : d[c-1]; end
         default: begin
            e.res = {d[23:16], d[31:24], d[7:0], d[15:8]};
            e.c   = (e.res[7:0] == 0) || (e.res[15:8] == 0);
         end
      endcase
      e.s = e.res[31];
      e.z = (op == 2'b11) ? (e.res[15:0] == 0) : (e.res == 0);
      return e;
   endfunction

   task automatic step(input logic v, input logic [1:0] op, input logic [31:0] d,
                       input logic [4:0] c, input logic rdy);
      exp_t e;
      string rt, ct, ft;
      @(negedge clk);
      if (was_stalled) chk("R12 held result", out_result, stalled_res);
      in_valid = v; in_op = op; in_data = d; in_count = c; out_ready = rdy;
      #1;
      chk("R11 in_ready", {31'b0, in_ready}, {31'b0, (!out_valid || out_ready)});
      chk("R11 out_valid vs outstanding", {31'b0, out_valid}, {31'b0, (q.size() > 0)});
      if (out_valid && out_ready && q.size() > 0) begin
         e = q.pop_front();
         case (e.op)
            2'b00: rt = "R1 shl result";
            2'b01: rt = "R2 shr result";
            2'b10: rt = "R3 sar result";
            default: rt = "R4 swap result";
         endcase
         if (e.op == 2'b11) begin ct = "R9 swap carry"; ft = "R8 swap zero"; end
         else begin ct = "R6/R5 shift carry"; ft = "R7 shift zero"; end
         chk(rt, out_result, e.res);
         chk(ct, {31'b0, out_carry}, {31'b0, e.c});
         chk(ft, {31'b0, out_zero}, {31'b0, e.z});
         chk((e.op == 2'b11) ? "R10 swap sign" : "R7 shift sign", {31'b0, out_sign}, {31'b0, e.s});
         chk((e.op == 2'b11) ? "R10 swap ovf" : "R7 shift ovf", {31'b0, out_ovf}, {31'b0, e.v});
      end
      was_stalled = out_valid && !out_ready;
      stalled_res = out_result;
      if (in_valid && in_ready) q.push_back(model(op, d, int'(c)));
   endtask

   initial begin
      logic [31:0] words [6];
      words[0] = 32'h8000_0001; words[1] = 32'h7FFF_FFFE; words[2] = 32'hDEAD_BEEF;
      words[3] = 32'h0000_0000; words[4] = 32'hFFFF_FFFF; words[5] = 32'h1234_5678;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R13 out_valid after reset", {31'b0, out_valid}, 32'd0);
      chk("R13 in_ready after reset", {31'b0, in_ready}, 32'd1);
      rst_n = 1'b1;
      // counts 0, 1, 31 for each shift (R5, R6)
      for (int op = 0; op < 3; op++)
         for (int w = 0; w < 6; w++) begin
            step(1, 2'(op), words[w], 5'd0, 1);
            step(1, 2'(op), words[w], 5'd1, 1);
            step(1, 2'(op), words[w], 5'd31, 1);
         end
      // byte swap zero and carry corner cases (R8, R9, R10)
      step(1, 2'b11, 32'hABCD_0000, 5'd7, 1);
      step(1, 2'b11, 32'h0000_00FF, 5'd0, 1);
      step(1, 2'b11, 32'h0000_FF00, 5'd3, 1);
      step(1, 2'b11, 32'h8000_1234, 5'd0, 1);
      step(1, 2'b11, 32'h0000_0000, 5'd0, 1);
      step(1, 2'b11, 32'h0012_3400, 5'd31, 1);
      // stall then release (R12)
      step(1, 2'b10, 32'h8765_4321, 5'd4, 0);
      step(1, 2'b00, 32'h0000_0003, 5'd30, 0);
      step(0, 2'b00, 32'h0, 5'd0, 0);
      step(0, 2'b00, 32'h0, 5'd0, 1);
      // random traffic
      for (int i = 0; i < 4000; i++)
         step(($urandom % 4) != 0, 2'($urandom), $urandom, 5'($urandom), ($urandom % 3) != 0);
      repeat (4) step(0, 2'b00, 32'h0, 5'd0, 1);
      chk("R11 queue drained", q.size(), 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R11: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule